// File: doc/BRIEF.md
# External Interrupt Request Controller

This block conditions two active-low external interrupt request pins, called pin A and pin B, before they reach the processor core. Each pin passes through a two-flop synchronizer. Its request is then formed in one of two ways. In level mode the request follows the low level of the pin. In edge mode a falling edge is latched and held until the core acknowledges that source.

The block has a 16-bit control/status word. It holds the two sensitivity selects and a global disable. It also shows the synchronized pin levels and the vector number of the last interrupt the core accepted. While the chip is in a stop or wait low-power mode, both pins are treated as level-sensitive, whatever their selects hold.

Out of reset, the block presents a fixed reset vector address to the core. It keeps presenting it for a short, fixed handshake after reset is released.

Top module: `xirq_ctrl`

## Requirements
- R1: After reset, `reg_rdata` reads 16'h001C with both pins high, and both request outputs are low.
- R2: With a pin's select bit at 0, its request rises two clock edges after the pin goes low and falls two edges after the pin returns high.
- R3: With a pin's select bit at 1, a falling edge raises its request three edges later. The request stays high after the pin returns high, until `ack_valid` is sampled with `ack_vec` equal to that pin's vector number (`VEC_A` or `VEC_B`).
- R4: While `lp_stop` or `lp_wait` is high, both pins behave as in R2, whatever their select bits hold.
- R5: Bit 5 is a global disable. At 1 both requests are held low. An edge latched before or during the disable is kept, and its request reappears once bit 5 returns to 0.
- R6: Bits 3 and 2 return the synchronized levels of pin B and pin A respectively, two edges after a pin change.
- R7: Bit 4 always reads 1 and bits 15:13 always read 0. Writes change neither of these, nor the read-only field in bits 12:6.
- R8: Bits 12:6 take the value of `ack_vec` one edge after every cycle with `ack_valid` high, and hold otherwise.
- R9: `rvec_valid` is high and `rvec_addr` equals `RST_ADDR` while `rst_n` is low. Both stay so until the second rising edge after `rst_n` rises. After that `rvec_valid` is 0 and `rvec_addr` is 0.
- R10: A cycle with `reg_we` high loads bit 5 (disable), bit 1 (pin B select) and bit 0 (pin A select) from `reg_wdata`. These bits are visible on `reg_rdata` after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Write strobe for the control word |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Current control/status word |
| pin_a_n | input | 1 | External request A, active low, asynchronous |
| pin_b_n | input | 1 | External request B, active low, asynchronous |
| lp_stop | input | 1 | Stop mode indicator |
| lp_wait | input | 1 | Wait mode indicator |
| ack_valid | input | 1 | Core has accepted an interrupt this cycle |
| ack_vec | input | 7 | Vector number accepted by the core |
| irq_a_req | output | 1 | Request for source A |
| irq_b_req | output | 1 | Request for source B |
| rvec_valid | output | 1 | Reset vector is being presented |
| rvec_addr | output | 16 | Reset vector address, 0 when not presented |

## Verification
The edge-hold property assumes that the core acknowledges only with a vector number that belongs to the source it serves. It also assumes that the low-power indicators are steady for the whole cycle in which they are sampled. The bench drives every input at the falling clock edge and clears any pending edge with an explicit acknowledge before each new configuration. The sweep covers every combination of the two select bits, the disable bit and the three power states (normal, stop, wait), on each pin in turn.

// File: rtl/xirq_ctrl.sv
module xirq_ctrl #(
  parameter int              VEC_W    = 7,
  parameter int              ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] RST_ADDR = 16'h0200,
  parameter logic [VEC_W-1:0]  VEC_A    = 7'h02,
  parameter logic [VEC_W-1:0]  VEC_B    = 7'h03
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [15:0]       reg_wdata,
  output logic [15:0]       reg_rdata,
  input  logic              pin_a_n,
  input  logic              pin_b_n,
  input  logic              lp_stop,
  input  logic              lp_wait,
  input  logic              ack_valid,
  input  logic [VEC_W-1:0]  ack_vec,
  output logic              irq_a_req,
  output logic              irq_b_req,
  output logic              rvec_valid,
  output logic [ADDR_W-1:0] rvec_addr
);

  localparam int NPIN = 2;

  logic [NPIN-1:0]  s1, s2, s3, pend, edge_sel, eff, fall, hit, req;
  logic             dis;
  logic [VEC_W-1:0] vec_q;
  logic [1:0]       rcnt;
  logic             lowp;

  assign lowp = lp_stop | lp_wait;
  assign eff  = edge_sel & {NPIN{~lowp}};
  assign fall = s3 & ~s2;
  assign hit  = {ack_valid && (ack_vec == VEC_B), ack_valid && (ack_vec == VEC_A)};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '1;
      s2 <= '1;
      s3 <= '1;
    end else begin
      s1 <= {pin_b_n, pin_a_n};
      s2 <= s1;
      s3 <= s2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= '0;
    else        pend <= (pend & ~hit) | (fall & eff);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dis      <= 1'b0;
      edge_sel <= '0;
    end else if (reg_we) begin
      dis      <= reg_wdata[5];
      edge_sel <= reg_wdata[1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         vec_q <= '0;
    else if (ack_valid) vec_q <= ack_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            rcnt <= 2'd0;
    else if (rcnt != 2'd2) rcnt <= rcnt + 2'd1;
  end

  assign req        = {NPIN{~dis}} & ((eff & pend) | (~eff & ~s2));
  assign irq_a_req  = req[0];
  assign irq_b_req  = req[1];
  assign rvec_valid = (rcnt != 2'd2);
  assign rvec_addr  = rvec_valid ? RST_ADDR : '0;
  assign reg_rdata  = {3'b000, vec_q, dis, 1'b1, s2[1], s2[0], edge_sel[1], edge_sel[0]};

endmodule

module xirq_ctrl_chk #(
  parameter int              VEC_W    = 7,
  parameter int              ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] RST_ADDR = 16'h0200,
  parameter logic [VEC_W-1:0]  VEC_A    = 7'h02,
  parameter logic [VEC_W-1:0]  VEC_B    = 7'h03
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic [15:0]       reg_rdata,
  input logic              lp_stop,
  input logic              lp_wait,
  input logic              ack_valid,
  input logic [VEC_W-1:0]  ack_vec,
  input logic              irq_a_req,
  input logic              irq_b_req,
  input logic              rvec_valid,
  input logic [ADDR_W-1:0] rvec_addr
);

  logic [1:0] edges;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             edges <= 2'd0;
    else if (edges != 2'd3) edges <= edges + 2'd1;
  end

  p_disable_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[5] |-> (!irq_a_req && !irq_b_req));

  p_fixed_bits_r7: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[4] && (reg_rdata[15:13] == 3'b000));

  p_lowpower_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((lp_stop || lp_wait) && !reg_rdata[5]) |->
      ((irq_a_req == !reg_rdata[2]) && (irq_b_req == !reg_rdata[3])));

  p_vec_capture_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |=> (reg_rdata[12:6] == $past(ack_vec)));

  p_vec_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_valid |=> $stable(reg_rdata[12:6]));

  p_edge_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_a_req && reg_rdata[0] && !lp_stop && !lp_wait && !reg_we &&
     !(ack_valid && ack_vec == VEC_A)) |=> (irq_a_req || lp_stop || lp_wait));

  p_rvec_window_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rvec_valid == (edges < 2'd2)) &&
    (rvec_addr == (rvec_valid ? RST_ADDR : '0)));

  always @(negedge clk) begin
    if (!rst_n) begin
      a_rvec_in_reset_r9: assert (rvec_valid && rvec_addr == RST_ADDR);
    end
  end

endmodule

bind xirq_ctrl xirq_ctrl_chk #(
  .VEC_W(VEC_W), .ADDR_W(ADDR_W), .RST_ADDR(RST_ADDR), .VEC_A(VEC_A), .VEC_B(VEC_B)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_rdata(reg_rdata),
  .lp_stop(lp_stop), .lp_wait(lp_wait), .ack_valid(ack_valid), .ack_vec(ack_vec),
  .irq_a_req(irq_a_req), .irq_b_req(irq_b_req),
  .rvec_valid(rvec_valid), .rvec_addr(rvec_addr)
);

// File: tb/sim_xirq_ctrl.sv
module sim_xirq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] RADDR = 16'h0200;
  localparam logic [6:0]  VA = 7'h02;
  localparam logic [6:0]  VB = 7'h03;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [1:0]  pins_n = 2'b11;
  logic        lp_stop = 1'b0, lp_wait = 1'b0;
  logic        ack_valid = 1'b0;
  logic [6:0]  ack_vec = '0;
  logic        irq_a_req, irq_b_req, rvec_valid;
  logic [15:0] rvec_addr;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xirq_ctrl #(.RST_ADDR(RADDR), .VEC_A(VA), .VEC_B(VB)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .pin_a_n(pins_n[0]), .pin_b_n(pins_n[1]),
    .lp_stop(lp_stop), .lp_wait(lp_wait), .ack_valid(ack_valid), .ack_vec(ack_vec),
    .irq_a_req(irq_a_req), .irq_b_req(irq_b_req),
    .rvec_valid(rvec_valid), .rvec_addr(rvec_addr)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] d);
    reg_we = 1'b1; reg_wdata = d;
    step(1);
    reg_we = 1'b0;
  endtask

  task automatic ack(input logic [6:0] v);
    ack_valid = 1'b1; ack_vec = v;
    step(1);
    ack_valid = 1'b0;
  endtask

  function automatic logic req_of(input int i);
    return (i == 0) ? irq_a_req : irq_b_req;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    step(2);
    check("R9 vector valid in reset", {31'd0, rvec_valid}, 1);
    check("R9 vector addr in reset", rvec_addr, RADDR);
    rst_n = 1'b1;
    step(1);
    check("R9 vector held after first edge", {31'd0, rvec_valid}, 1);
    check("R9 addr held after first edge", rvec_addr, RADDR);
    step(1);
    check("R9 vector dropped at second edge", {31'd0, rvec_valid}, 0);
    check("R9 addr cleared", rvec_addr, 0);
    check("R1 reset word", reg_rdata, 16'h001C);
    check("R1 reset requests", {30'd0, irq_b_req, irq_a_req}, 0);

    wr(16'hFFFF);
    check("R7 R10 write all ones", reg_rdata, 16'h003F);
    wr(16'h0000);
    check("R7 R10 write zeros", reg_rdata, 16'h001C);

    ack(7'h55);
    check("R8 vector captured", {25'd0, reg_rdata[12:6]}, 32'h55);
    step(3);
    check("R8 vector held", {25'd0, reg_rdata[12:6]}, 32'h55);

    for (int lp = 0; lp < 3; lp++) begin
      for (int cfg = 0; cfg < 8; cfg++) begin
        automatic logic ea = cfg[0];
        automatic logic eb = cfg[1];
        automatic logic ds = cfg[2];
        automatic logic [15:0] ctl = {10'd0, ds, 3'b000, eb, ea};
        lp_stop = (lp == 1);
        lp_wait = (lp == 2);
        for (int i = 0; i < 2; i++) begin
          automatic logic eff = ((i == 0) ? ea : eb) && (lp == 0);
          automatic logic [6:0] v = (i == 0) ? VA : VB;
          wr(ctl);
          check("R10 control readback", {26'd0, reg_rdata[5], reg_rdata[1:0]},
                {29'd0, ds, eb, ea});
          pins_n = 2'b11;
          step(3);
          ack(VA);
          ack(VB);
          pins_n[i] = 1'b0;
          step(1);
          check("R2 R3 no request after one edge", {31'd0, req_of(i)}, 0);
          step(2);
          check("R6 pin state low", {30'd0, reg_rdata[3:2]}, (i == 0) ? 2'b10 : 2'b01);
          check((eff ? "R3 R5 edge request" : (lp != 0 ? "R4 R5 forced level request" : "R2 R5 level request")),
                {31'd0, req_of(i)}, {31'd0, !ds});
          check("R2 other pin quiet", {31'd0, req_of(1 - i)}, 0);
          pins_n[i] = 1'b1;
          step(3);
          check("R6 pin state high", {30'd0, reg_rdata[3:2]}, 2'b11);
          check((eff ? "R3 R5 edge held" : "R2 R4 level dropped"),
                {31'd0, req_of(i)}, {31'd0, eff && !ds});
          if (ds) wr({14'd0, eb, ea});
          check((eff ? "R5 pending retained" : "R4 R5 no latch in level"),
                {31'd0, req_of(i)}, {31'd0, eff});
          ack(v);
          check("R3 cleared by ack", {31'd0, req_of(i)}, 0);
          check("R8 ack vector captured", {25'd0, reg_rdata[12:6]}, {25'd0, v});
        end
      end
    end

    lp_stop = 1'b0; lp_wait = 1'b0;
    wr(16'h0001);
    pins_n[0] = 1'b0; step(3);
    pins_n[0] = 1'b1; step(3);
    ack(VB);
    check("R3 other source ack does not clear", {31'd0, irq_a_req}, 1);
    ack(VA);
    check("R3 own ack clears", {31'd0, irq_a_req}, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule